// File: doc/BRIEF.md
# Interrupt Source Routing Bank

This block holds the per-source setup of a multiprocessor interrupt controller and turns live source requests into per-CPU interrupt lines. Every source owns a 32-byte window in a 32-bit register space. The window holds three registers. The first combines a mask bit, a priority and a vector. The second is a CPU bitmap. The third is an output-class selector that steers the source to the normal, critical or machine-check line.

For each source that is requested, unmasked and has a nonzero priority, the block raises the selected class line on every CPU whose bit is set in that source's bitmap. The lines of all sources are ORed together and registered. A mode input enables or disables the class selector. When the selector is disabled, its reads return all ones and writes to it are dropped.

Priority arbitration, acknowledge handling, timers, inter-processor interrupts and message-signalled decoding belong to neighbouring blocks.

Top module: `irq_route_bank`

## Requirements
- R1: The 16-bit byte offset `addr` decodes as follows. Source index = `addr[15:5]`, and the register within the window = `addr[4:0]`. 0x00 selects the vector/priority register, 0x10 the destination bitmap and 0x18 the class selector.
- R2: The vector/priority register has these fields:
  - bit 31: mask
  - bits 19:16: priority
  - bits 15:0: vector

  Only these bits can be written, and every other bit reads as zero. The reset value is 0x80000000, which means masked.
- R3: A read of any other offset in a window returns 0xFFFFFFFF, and a write to it changes nothing. The same holds for an index at or above NSRC.
- R4: A class write with class_en high uses only `wdata[7:0]`. 0x00 selects normal, 0x01 critical and 0x02 machine check, and any other value selects normal. A class read returns the current code (0, 1 or 2), zero-extended. The reset code is 0.
- R5: While class_en is low, class reads return 0xFFFFFFFF and class writes leave the stored class unchanged.
- R6: The destination register is a CPU bitmap in which bit n routes the source to CPU n. Bits at or above NCPU read as zero. The reset value is 1, so a source goes to CPU 0 only.
- R7: Line c of CPU k is high exactly when at least one source meets all of these conditions:
  - it is requested on `src_in`
  - it is unmasked
  - it has a nonzero priority
  - it has bit k set in its destination bitmap
  - it has class c selected

  The lines update one clock after the change that causes them.
- R8: `rdata` is loaded only in the clock that samples `rd_en` and is valid from the next cycle until the next read. After reset, `rdata` and all lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| class_en | input | 1 | Enables the class selector register |
| src_in | input | NSRC | Level request per source |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 16 | Byte offset into the source register space |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq_norm | output | NCPU | Normal interrupt line per CPU |
| irq_crit | output | NCPU | Critical interrupt line per CPU |
| irq_mchk | output | NCPU | Machine-check line per CPU |

## Verification
The embedded assertions check several rules on every cycle:
- all lines go quiet one clock after no source is live
- undecoded and disabled-class reads return all ones
- class reads only ever return codes 0 to 2
- reserved vector/priority bits read as zero
- `rdata` holds between reads

Other behaviour only the bench's scenarios can show. These are the exact mapping of every 8-bit class value, the bitmap-to-CPU routing, and that ignored writes leave the neighbouring registers untouched. The same applies to the OR of several sources onto one line, which the bench compares against its own model for every input pattern.

// File: rtl/irq_route_bank.sv
module irq_route_bank #(
  parameter int NSRC = 16,
  parameter int NCPU = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            class_en,
  input  logic [NSRC-1:0] src_in,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [15:0]     addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [NCPU-1:0] irq_norm,
  output logic [NCPU-1:0] irq_crit,
  output logic [NCPU-1:0] irq_mchk
);

  localparam logic [4:0] OFF_VP  = 5'h00;
  localparam logic [4:0] OFF_DST = 5'h10;
  localparam logic [4:0] OFF_CLS = 5'h18;

  logic            msk [NSRC];
  logic [3:0]      pri [NSRC];
  logic [15:0]     vec [NSRC];
  logic [NCPU-1:0] dst [NSRC];
  logic [1:0]      cls [NSRC];

  logic [10:0] idx;
  logic [4:0]  off;
  logic        hit;
  logic        bad;
  logic [31:0] rd_next;
  logic [NSRC-1:0] live;
  logic [NCPU-1:0] nx_norm, nx_crit, nx_mchk;

  assign idx = addr[15:5];
  assign off = addr[4:0];
  assign hit = (32'(idx) < NSRC);
  assign bad = !hit || !(off == OFF_VP || off == OFF_DST || off == OFF_CLS);

  function automatic logic [1:0] class_code(input logic [7:0] v);
    case (v)
      8'h01:   return 2'd1;
      8'h02:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) begin
        msk[s] <= 1'b1;
        pri[s] <= '0;
        vec[s] <= '0;
        dst[s] <= NCPU'(1);
        cls[s] <= 2'd0;
      end
    end else if (wr_en) begin
      for (int s = 0; s < NSRC; s++) begin
        if (idx == 11'(s)) begin
          case (off)
            OFF_VP: begin
              msk[s] <= wdata[31];
              pri[s] <= wdata[19:16];
              vec[s] <= wdata[15:0];
            end
            OFF_DST: dst[s] <= wdata[NCPU-1:0];
            OFF_CLS: if (class_en) cls[s] <= class_code(wdata[7:0]);
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_next = 32'hFFFF_FFFF;
    for (int s = 0; s < NSRC; s++) begin
      if (idx == 11'(s)) begin
        case (off)
          OFF_VP:  rd_next = {msk[s], 11'd0, pri[s], vec[s]};
          OFF_DST: rd_next = 32'(dst[s]);
          OFF_CLS: rd_next = class_en ? {30'd0, cls[s]} : 32'hFFFF_FFFF;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    nx_norm = '0;
    nx_crit = '0;
    nx_mchk = '0;
    for (int s = 0; s < NSRC; s++) begin
      live[s] = src_in[s] && !msk[s] && (pri[s] != 4'd0);
      if (live[s]) begin
        case (cls[s])
          2'd1:    nx_crit = nx_crit | dst[s];
          2'd2:    nx_mchk = nx_mchk | dst[s];
          default: nx_norm = nx_norm | dst[s];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      irq_norm <= '0;
      irq_crit <= '0;
      irq_mchk <= '0;
    end else begin
      if (rd_en) rdata <= rd_next;
      irq_norm <= nx_norm;
      irq_crit <= nx_crit;
      irq_mchk <= nx_mchk;
    end
  end

  assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|live) |=> (irq_norm == '0 && irq_crit == '0 && irq_mchk == '0));

  assert_bad_offset_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bad) |=> rdata == 32'hFFFF_FFFF);

  assert_class_off_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !bad && off == OFF_CLS && !class_en) |=> rdata == 32'hFFFF_FFFF);

  assert_class_code_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !bad && off == OFF_CLS && class_en) |=> rdata <= 32'd2);

  assert_vp_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !bad && off == OFF_VP) |=> (rdata & 32'h7FF0_0000) == 32'd0);

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/irq_route_bank_test.sv
`timescale 1ns/1ps
module irq_route_bank_test;
  localparam int NS = 4;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          class_en = 1'b1;
  logic [NS-1:0] src_in = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [15:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] irq_norm, irq_crit, irq_mchk;

  int total = 0;
  int fails = 0;
  logic [31:0] mvp [NS];
  logic [31:0] mdst [NS];
  logic [1:0]  mcls [NS];

  irq_route_bank #(.NSRC(NS), .NCPU(NC)) uut (
    .clk(clk), .rst_n(rst_n), .class_en(class_en), .src_in(src_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_norm(irq_norm), .irq_crit(irq_crit), .irq_mchk(irq_mchk));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [1:0] code_of(input logic [7:0] v);
    return (v == 8'h01) ? 2'd1 : (v == 8'h02) ? 2'd2 : 2'd0;
  endfunction

  function automatic logic [3*NC-1:0] model(input logic [NS-1:0] req);
    logic [NC-1:0] n, c, m;
    n = '0; c = '0; m = '0;
    for (int s = 0; s < NS; s++) begin
      if (req[s] && !mvp[s][31] && mvp[s][19:16] != 4'd0) begin
        if (mcls[s] == 2'd1) c = c | mdst[s][NC-1:0];
        else if (mcls[s] == 2'd2) m = m | mdst[s][NC-1:0];
        else n = n | mdst[s][NC-1:0];
      end
    end
    return {m, c, n};
  endfunction

  initial begin
    #1000000;
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp;
    logic [3*NC-1:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset rdata", rdata, 32'd0);
    chk("R8 reset lines", 32'({irq_mchk, irq_crit, irq_norm}), 32'd0);

    for (int s = 0; s < NS; s++) begin
      rd(16'(s*32 + 16'h00), d); chk("R2 reset vp", d, 32'h8000_0000);
      rd(16'(s*32 + 16'h10), d); chk("R6 reset dst", d, 32'd1);
      rd(16'(s*32 + 16'h18), d); chk("R4 reset class", d, 32'd0);
      mvp[s] = 32'h8000_0000; mdst[s] = 32'd1; mcls[s] = 2'd0;
    end

    wr(16'h0020, 32'hFFFF_FFFF); mvp[1] = 32'h800F_FFFF;
    rd(16'h0020, d); chk("R2 vp writable bits", d, 32'h800F_FFFF);
    wr(16'h0030, 32'hFFFF_FFFF); mdst[1] = 32'h0000_000F;
    rd(16'h0030, d); chk("R6 dst upper bits zero", d, 32'h0000_000F);

    for (int o = 0; o < 32; o += 4) begin
      if (o != 0 && o != 16 && o != 24) wr(16'(32 + o), 32'h0000_0000);
    end
    for (int o = 0; o < 32; o += 4) begin
      rd(16'(32 + o), d);
      exp = (o == 0) ? 32'h800F_FFFF : (o == 16) ? 32'h0000_000F :
            (o == 24) ? 32'd0 : 32'hFFFF_FFFF;
      chk("R3 R1 offset sweep", d, exp);
    end
    wr(16'(NS*32), 32'h0000_0001);
    rd(16'(NS*32), d); chk("R3 index out of range", d, 32'hFFFF_FFFF);
    rd(16'h0000, d); chk("R3 R1 src0 untouched", d, 32'h8000_0000);

    for (int v = 0; v < 256; v++) begin
      wr(16'h0058, 32'hABCD_EF00 | 32'(v));
      rd(16'h0058, d);
      chk("R4 class code map", d, 32'(code_of(8'(v))));
    end
    wr(16'h0058, 32'h0000_0002); mcls[2] = 2'd2;

    class_en = 1'b0;
    rd(16'h0058, d); chk("R5 class read disabled", d, 32'hFFFF_FFFF);
    wr(16'h0058, 32'h0000_0001);
    class_en = 1'b1;
    rd(16'h0058, d); chk("R5 class write dropped", d, 32'd2);

    repeat (3) @(negedge clk);
    chk("R8 rdata held", rdata, 32'd2);

    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int s = 0; s < NS; s++) begin
        mvp[s] = {((s + cfg) % 5 == 0), 11'd0, 4'((s*3 + cfg) % 4), 16'(s*257 + cfg)};
        mdst[s] = 32'((s*5 + cfg*3) % 16);
        mcls[s] = code_of(8'((s + cfg) % 4));
        wr(16'(s*32), mvp[s]);
        wr(16'(s*32 + 16), mdst[s]);
        wr(16'(s*32 + 24), 32'((s + cfg) % 4));
      end
      for (int p = 0; p < 16; p++) begin
        @(negedge clk);
        prev = {irq_mchk, irq_crit, irq_norm};
        src_in = 4'(p);
        #1;
        chk("R7 lines not yet changed", 32'({irq_mchk, irq_crit, irq_norm}), 32'(prev));
        @(negedge clk);
        chk("R7 routing", 32'({irq_mchk, irq_crit, irq_norm}), 32'(model(4'(p))));
      end
    end

    src_in = '0;
    @(negedge clk); @(negedge clk);
    chk("R7 idle lines zero", 32'({irq_mchk, irq_crit, irq_norm}), 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule